// File: doc/BRIEF.md
# Pruned-Width CIC Decimation Filter

This block lowers the sample rate of a signed stream by a power-of-two factor R = 2^LOG2_R. It uses a cascaded integrator-comb structure. STAGES integrators run at the input rate. They feed a rate divider, which passes one value onward for every R accepted inputs. STAGES comb sections then run at the reduced rate. The filter uses only adders, subtractors and registers.

The width of each stage follows from bit growth, so most stages are narrower than the full worst-case word. Every stage keeps its most significant bit at the full-precision weight 2^(B-1), where B = IN_W + STAGES·LOG2_R. Bits are removed only at the least significant end, by truncation toward minus infinity. All arithmetic wraps in two's complement, and the combs cancel any integrator overflow. The output is the top OUT_W bits of the last comb.

The defaults are a 10-bit input, 4 stages and LOG2_R = 14, which gives a 66-bit full-precision word, and a 16-bit output.

Top module: `cic_prune_decim`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is 0. All accumulators, delays and the input counter clear to zero.
- R2: Exactly one valid_o pulse, one cycle long, is produced for every R accepted inputs (an input is accepted when valid_i is 1 at a rising clock edge). valid_o is high in the second cycle after the edge that accepts the R-th input.
- R3: The full-precision width is B = IN_W + STAGES·LOG2_R. Integrator k (k = 1..STAGES) is max(B − (k−1)·LOG2_R, OUT_W) bits wide. Comb c (c = 1..STAGES) is min(width of the previous stage, OUT_W + GUARD_W·(STAGES−c+1)) bits wide. Every stage's MSB has weight 2^(B−1). Going from a wider stage to a narrower one drops the surplus LSBs by arithmetic shift right (floor).
- R4: data_i is a two's-complement value, sign-extended to B bits before it enters integrator 1. On each accepted input, every integrator adds its input modulo 2^(its width). Integrator k ≥ 2 takes the value integrator k−1 held before that same edge.
- R5: On the R-th accepted input, the rate divider captures the last integrator's value from before that edge. On the next cycle every comb computes its input minus its own previous input (delay of one decimated sample), modulo its width. Comb c ≥ 2 takes the output comb c−1 held before that update.
- R6: data_o is the top OUT_W bits of the last comb, as a two's-complement value. data_o changes only in a cycle where valid_o is high.
- R7: Cycles with valid_i low change no state: the output sequence depends only on the accepted samples, however they are spaced.
- R8: A reset in the middle of the stream restarts the input count, so the first pulse after reset comes after R new accepted inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | IN_W | Signed input sample |
| valid_o | output | 1 | Decimated output strobe |
| data_o | output | OUT_W | Signed decimated output, truncated |

## Verification
The bench sweeps a small configuration (4-bit input, 2 stages, R = 4, 4-bit output, 1 guard bit). In that configuration the second integrator, the second comb and the output stage all drop bits. It compares every output against an arithmetic model of R3 to R5.

Full-scale constant inputs of both signs force the integrators to wrap. A design without modular arithmetic or with the wrong sign extension gives wrong DC values. Exhaustive pairs of input values and random data with random gaps between strobes catch several faults: truncation from the wrong end, a stage that reads a neighbour's new value instead of its old one, and a gap cycle that is counted as an input. The latency check catches a missing pipeline register or an extra one. The reset in the middle of the stream catches an input counter that keeps its count.

// File: rtl/cic_pkg.sv
package cic_pkg;

  function automatic int full_w(int iw, int n, int l);
    return iw + n * l;
  endfunction

  // integrator k, counted from 1
  function automatic int int_w(int k, int iw, int n, int l, int ow);
    int w;
    w = full_w(iw, n, l) - (k - 1) * l;
    if (w < ow) w = ow;
    return w;
  endfunction

  // comb c, counted from 1; never wider than the stage before it
  function automatic int comb_w(int c, int iw, int n, int l, int ow, int g);
    int w;
    w = int_w(n, iw, n, l, ow);
    for (int j = 1; j <= c; j++) begin
      if (ow + g * (n - j + 1) < w) w = ow + g * (n - j + 1);
    end
    return w;
  endfunction

endpackage

// File: rtl/cic_int_chain.sv
module cic_int_chain #(
  parameter int IN_W   = 10,
  parameter int STAGES = 4,
  parameter int LOG2_R = 14,
  parameter int OUT_W  = 16,
  localparam int FullW = cic_pkg::full_w(IN_W, STAGES, LOG2_R)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  output logic [FullW-1:0] last_o
);

  // taps are MSB-aligned at the full-precision weight, low bits zero
  logic [FullW-1:0] tap [STAGES+1];

  assign tap[0] = {{(FullW-IN_W){data_i[IN_W-1]}}, data_i};

  for (genvar k = 0; k < STAGES; k++) begin : g_int
    localparam int W = cic_pkg::int_w(k + 1, IN_W, STAGES, LOG2_R, OUT_W);
    logic [W-1:0] acc_q;
    logic [W-1:0] add_in;

    assign add_in = tap[k][FullW-1 -: W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      acc_q <= '0;
      else if (valid_i) acc_q <= acc_q + add_in;
    end

    if (W == FullW) begin : g_full
      assign tap[k+1] = acc_q;
    end else begin : g_pad
      assign tap[k+1] = {acc_q, {(FullW-W){1'b0}}};
    end
  end

  assign last_o = tap[STAGES];

endmodule

// File: rtl/cic_rate_div.sv
module cic_rate_div #(
  parameter int LOG2_R = 14,
  parameter int FULL_W = 66
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FULL_W-1:0] smp_i,
  output logic              dec_vld_o,
  output logic [FULL_W-1:0] dec_o
);

  logic [LOG2_R-1:0] cnt_q;
  logic              wrap;

  assign wrap = valid_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      dec_vld_o <= 1'b0;
      dec_o     <= '0;
    end else begin
      if (valid_i) cnt_q <= cnt_q + 1'b1;
      dec_vld_o <= wrap;
      if (wrap) dec_o <= smp_i;
    end
  end

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int IN_W    = 10,
  parameter int STAGES  = 4,
  parameter int LOG2_R  = 14,
  parameter int OUT_W   = 16,
  parameter int GUARD_W = 2,
  localparam int FullW  = cic_pkg::full_w(IN_W, STAGES, LOG2_R)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_vld_i,
  input  logic [FullW-1:0] dec_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o
);

  logic [FullW-1:0] tap [STAGES+1];

  assign tap[0] = dec_i;

  for (genvar c = 0; c < STAGES; c++) begin : g_comb
    localparam int W = cic_pkg::comb_w(c + 1, IN_W, STAGES, LOG2_R, OUT_W, GUARD_W);
    logic [W-1:0] din;
    logic [W-1:0] dly_q;
    logic [W-1:0] out_q;

    assign din = tap[c][FullW-1 -: W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dly_q <= '0;
        out_q <= '0;
      end else if (dec_vld_i) begin
        dly_q <= din;
        out_q <= din - dly_q;
      end
    end

    if (W == FullW) begin : g_full
      assign tap[c+1] = out_q;
    end else begin : g_pad
      assign tap[c+1] = {out_q, {(FullW-W){1'b0}}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= dec_vld_i;
  end

  assign data_o = tap[STAGES][FullW-1 -: OUT_W];

endmodule

// File: rtl/cic_prune_decim.sv
module cic_prune_decim #(
  parameter int IN_W    = 10,
  parameter int STAGES  = 4,
  parameter int LOG2_R  = 14,
  parameter int OUT_W   = 16,
  parameter int GUARD_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o
);

  localparam int FullW = cic_pkg::full_w(IN_W, STAGES, LOG2_R);

  logic [FullW-1:0] int_last;
  logic [FullW-1:0] dec_smp;
  logic             dec_vld;

  cic_int_chain #(
    .IN_W(IN_W), .STAGES(STAGES), .LOG2_R(LOG2_R), .OUT_W(OUT_W)
  ) int_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .last_o  (int_last)
  );

  cic_rate_div #(
    .LOG2_R(LOG2_R), .FULL_W(FullW)
  ) div_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .smp_i     (int_last),
    .dec_vld_o (dec_vld),
    .dec_o     (dec_smp)
  );

  cic_comb_chain #(
    .IN_W(IN_W), .STAGES(STAGES), .LOG2_R(LOG2_R), .OUT_W(OUT_W), .GUARD_W(GUARD_W)
  ) comb_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_vld_i (dec_vld),
    .dec_i     (dec_smp),
    .valid_o   (valid_o),
    .data_o    (data_o)
  );

endmodule

// File: rtl/cic_prune_decim_chk.sv
module cic_prune_decim_chk #(
  parameter int LOG2_R = 14,
  parameter int OUT_W  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] data_o,
  input logic             dec_vld
);

  // independent count of accepted inputs
  logic [LOG2_R-1:0] cnt_q;
  logic              hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= valid_i && (cnt_q == {LOG2_R{1'b1}});
      if (valid_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r1: assert (!valid_o && data_o == '0);
    end
  end

  p_dec_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld == hit_q);

  p_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_out_follows_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld |=> valid_o);

  p_out_needs_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(dec_vld));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !dec_vld);

endmodule

bind cic_prune_decim cic_prune_decim_chk #(
  .LOG2_R(LOG2_R), .OUT_W(OUT_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .data_o  (data_o),
  .dec_vld (dec_vld)
);

// File: tb/cic_prune_decim_tb_top.sv
`timescale 1ns/1ps
module cic_prune_decim_tb_top;

  localparam int IW = 4, NS = 2, LR = 2, OW = 4, GW = 1;
  localparam int RR = 1 << LR;
  localparam int BW = IW + NS * LR;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [IW-1:0] data_i = '0;
  logic          valid_o;
  logic [OW-1:0] data_o;

  cic_prune_decim #(
    .IN_W(IW), .STAGES(NS), .LOG2_R(LR), .OUT_W(OW), .GUARD_W(GW)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  always #4 clk_i = ~clk_i;

  int vectors = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // stage widths from R3
  int wi [NS];
  int wc [NS];
  longint integ [NS];
  longint comb [NS];
  longint dly [NS];
  int cnt;
  longint exp_q [$];
  int     expc_q [$];

  function automatic longint wrapw(longint v, int w);
    longint m;
    m = v & ((longint'(1) << w) - 1);
    if (m[w-1]) m = m - (longint'(1) << w);
    return m;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NS; k++) begin
      integ[k] = 0; comb[k] = 0; dly[k] = 0;
    end
    cnt = 0;
  endtask

  task automatic model_step(input longint x);
    longint oi [NS];
    longint oc [NS];
    longint din;
    for (int k = 0; k < NS; k++) oi[k] = integ[k];
    integ[0] = wrapw(integ[0] + (x >>> (BW - wi[0])), wi[0]);
    for (int k = 1; k < NS; k++)
      integ[k] = wrapw(integ[k] + (oi[k-1] >>> (wi[k-1] - wi[k])), wi[k]);
    cnt++;
    if (cnt == RR) begin
      cnt = 0;
      for (int c = 0; c < NS; c++) oc[c] = comb[c];
      for (int c = 0; c < NS; c++) begin
        din = (c == 0) ? (oi[NS-1] >>> (wi[NS-1] - wc[0])) : (oc[c-1] >>> (wc[c-1] - wc[c]));
        comb[c] = wrapw(din - dly[c], wc[c]);
        dly[c] = din;
      end
      exp_q.push_back(comb[NS-1] >>> (wc[NS-1] - OW));
      expc_q.push_back(cyc + 2);
    end
  endtask

  task automatic put(input int x);
    @(negedge clk_i);
    valid_i = 1'b1;
    data_i = IW'(x);
    model_step(longint'(x));
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      valid_i = 1'b0;
    end
  endtask

  // output monitor: R2 timing, R4/R5/R6 values, R7 no stray strobes
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (expc_q.size() > 0 && expc_q[0] == cyc) begin
        vectors++;
        if (!valid_o) begin
          fails++;
          $display("FAIL R2 cycle %0d valid_o=%0b expected 1", cyc, valid_o);
        end else if (longint'($signed(data_o)) != exp_q[0]) begin
          fails++;
          $display("FAIL R5/R6 data_o=%0d expected %0d", $signed(data_o), exp_q[0]);
        end
        void'(exp_q.pop_front());
        void'(expc_q.pop_front());
      end else if (valid_o) begin
        vectors++; fails++;
        $display("FAIL R7 stray valid_o=1 expected 0 at cycle %0d", cyc);
      end
    end
  end

  task automatic check_drained(input string tag);
    idle(4);
    vectors++;
    if (expc_q.size() != 0) begin
      fails++;
      $display("FAIL %s pending outputs=%0d expected 0", tag, expc_q.size());
    end
  endtask

  task automatic check_reset();
    vectors++;
    if (valid_o !== 1'b0 || data_o !== '0) begin
      fails++;
      $display("FAIL R1 valid_o=%0b data_o=%0h expected 0/0", valid_o, data_o);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired, got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    int w;
    // widths per R3
    for (int k = 1; k <= NS; k++) begin
      w = BW - (k - 1) * LR;
      wi[k-1] = (w < OW) ? OW : w;
    end
    w = wi[NS-1];
    for (int c = 1; c <= NS; c++) begin
      if (OW + GW * (NS - c + 1) < w) w = OW + GW * (NS - c + 1);
      wc[c-1] = w;
    end
    model_reset();
    repeat (3) @(negedge clk_i);
    check_reset();                       // R1
    rst_ni = 1'b1;

    // R4 ramp through all input codes
    for (int i = 0; i < 64; i++) put((i % 16) - 8);
    check_drained("R2");
    // R4 full-scale constants force wrapping
    for (int i = 0; i < 40; i++) put(7);
    for (int i = 0; i < 40; i++) put(-8);
    for (int i = 0; i < 40; i++) put((i % 2) ? 7 : -8);
    check_drained("R2");
    // R3 exhaustive value pairs
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++) begin
        put(a); put(b);
      end
    check_drained("R3");
    // R7 random data with random gaps
    lfsr = 8'hA5;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[1:0] == 2'b00) idle(int'(lfsr[4:2]) + 1);
      put(int'($signed(lfsr[7:4])));
    end
    check_drained("R7");

    // R8 reset after a partial count
    put(3); put(-2); put(5);
    idle(2);
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk_i);
    check_reset();                       // R1 mid-stream
    rst_ni = 1'b1;
    for (int i = 0; i < 48; i++) put(((i * 5) % 16) - 8);  // R8
    check_drained("R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule